// File: doc/BRIEF.md
# Narrowing Integer Divider

This block is the division unit of a small processor datapath. It receives a double-width dividend, which is the current contents of the destination register, and a single-width divisor taken from a source register. It also receives a size select and a signed/unsigned select. It then works out a half-width quotient and a half-width remainder over several clock cycles. Both values are packed into one destination-width result, so the caller can write the result straight back over the register that held the dividend.

There are two sizes. Byte size uses the low 16 bits of the dividend and the low 8 bits of the divisor. Word size uses all 32 bits of the dividend and all 16 bits of the divisor. The main loop is a restoring shift-and-subtract on magnitudes that produces one quotient bit per cycle. A separate final cycle applies the signs and checks the signed range. Division by zero and a quotient that does not fit its field are both reported as flags, and in either case the destination value is returned unchanged. The caller pulses `start`. `busy` stays high while the operation runs, and `done` pulses for one cycle when `result` and the flags are valid.

Top module: `divx_top`

## Requirements
- R1: In byte size without error, result[7:0] is the quotient, result[15:8] is the remainder, and result[31:16] repeats dividend[31:16]. Only dividend[15:0] and divisor[7:0] take part in the division.
- R2: In word size without error, result[15:0] is the quotient and result[31:16] is the remainder of dividend[31:0] divided by divisor[15:0].
- R3: With is_signed high, operands are two's complement, the quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R4: A divisor field of zero (divisor[7:0] in byte size, divisor[15:0] in word size) sets div_zero, clears overflow, zero and negative, and returns the dividend unchanged on result.
- R5: With a nonzero divisor, if the true quotient does not fit the field, overflow is set and result returns the dividend unchanged. The field is 0..2^N-1 unsigned, or -2^(N-1)..2^(N-1)-1 signed, where N is 8 for byte and 16 for word.
- R6: When there is no error, quo_zero is set exactly when the N-bit quotient field is zero, and quo_neg equals its top bit. Both flags are 0 when div_zero or overflow is set.
- R7: done is a one-cycle pulse. Counting from the clock edge that samples start, done rises after N+1 edges for a normal divide and after 1 edge for a divide by zero or an overflow that the high half already shows. busy is high from that first edge until done rises.
- R8: A start pulse that arrives while busy is high is ignored, and the running operation completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| size_word | input | 1 | 1 = 32/16 word size, 0 = 16/8 byte size |
| is_signed | input | 1 | 1 = two's complement operands |
| dividend | input | 32 | Destination register contents |
| divisor | input | 16 | Source register contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Packed remainder and quotient, or the unchanged dividend on error |
| quo_zero | output | 1 | Quotient field is zero |
| quo_neg | output | 1 | Quotient field top bit |
| div_zero | output | 1 | Divisor field was zero |
| overflow | output | 1 | Quotient did not fit its field |

## Verification
Directed operands cover the four sign combinations of signed byte division, which separates truncation toward zero from floor division and shows where the remainder sign comes from. The quotient values -2^(N-1) (legal) and +2^(N-1) (overflow) check the asymmetric signed bound that only the final cycle can catch. Byte operations with nonzero upper dividend and divisor bits show that those bits are ignored in the arithmetic and that the dividend's upper half passes through to the result. Random operands, shifted right by random amounts so that both fitting and overflowing quotients occur, are compared with a reference quotient and remainder, and a start pulse sent mid-operation checks that operands are captured only once.

// File: rtl/divx_pkg.sv
package divx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } divx_state_e;
endpackage

// File: rtl/divx_prep.sv
module divx_prep #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] dividend,
   input  logic [W-1:0]   divisor,
   input  logic           size_word,
   input  logic           is_signed,
   output logic [W-1:0]   p_init,
   output logic [W-1:0]   q_init,
   output logic [W-1:0]   d_mag,
   output logic           dvd_neg,
   output logic           dvs_neg,
   output logic           div_zero,
   output logic           hi_ovf
);
   localparam int H = W / 2;

   logic [2*W-1:0] dvd_ext, dvd_mag;
   logic [W-1:0]   dvs_ext;

   always_comb begin
      dvd_neg = is_signed & (size_word ? dividend[2*W-1] : dividend[W-1]);
      dvs_neg = is_signed & (size_word ? divisor[W-1] : divisor[H-1]);
      if (size_word) begin
         dvd_ext = dividend;
         dvs_ext = divisor;
      end else begin
         dvd_ext = {{W{dvd_neg}}, dividend[W-1:0]};
         dvs_ext = {{H{dvs_neg}}, divisor[H-1:0]};
      end
      dvd_mag = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
      d_mag   = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
      if (size_word) begin
         p_init = dvd_mag[2*W-1:W];
         q_init = dvd_mag[W-1:0];
      end else begin
         p_init = {{H{1'b0}}, dvd_mag[W-1:H]};
         q_init = {dvd_mag[H-1:0], {H{1'b0}}};
      end
      div_zero = (d_mag == '0);
      hi_ovf   = !div_zero && (p_init >= d_mag);
   end
endmodule

// File: rtl/divx_core.sv
module divx_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] p_init,
   input  logic [W-1:0] q_init,
   input  logic [W-1:0] d_init,
   output logic [W-1:0] rem_mag,
   output logic [W-1:0] quo_mag
);
   logic [W-1:0] p_q, q_q, d_q;
   logic [W:0]   trial, diff;
   logic         fits;

   always_comb begin
      trial = {p_q, q_q[W-1]};
      diff  = trial - {1'b0, d_q};
      fits  = (trial >= {1'b0, d_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= '0;
         q_q <= '0;
         d_q <= '0;
      end else if (load) begin
         p_q <= p_init;
         q_q <= q_init;
         d_q <= d_init;
      end else if (step) begin
         p_q <= fits ? diff[W-1:0] : trial[W-1:0];
         q_q <= {q_q[W-2:0], fits};
      end
   end

   assign rem_mag = p_q;
   assign quo_mag = q_q;

   // R2: restoring invariant, partial remainder stays below the divisor
   a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (p_q < d_q));
endmodule

// File: rtl/divx_fix.sv
module divx_fix #(
   parameter int W = 16
) (
   input  logic [W-1:0] q_mag,
   input  logic [W-1:0] r_mag,
   input  logic         size_word,
   input  logic         is_signed,
   input  logic         q_neg,
   input  logic         r_neg,
   output logic [W-1:0] quo_f,
   output logic [W-1:0] rem_f,
   output logic         ovf
);
   localparam int H = W / 2;
   localparam logic [W-1:0] LIM_W = W'(1) << (W - 1);
   localparam logic [W-1:0] LIM_B = W'(1) << (H - 1);
   localparam logic [W-1:0] MSK_B = {{H{1'b0}}, {H{1'b1}}};

   logic [W-1:0] lim, mask, qs, rs;

   always_comb begin
      lim   = size_word ? LIM_W : LIM_B;
      mask  = size_word ? '1 : MSK_B;
      ovf   = is_signed && (q_neg ? (q_mag > lim) : (q_mag >= lim));
      qs    = q_neg ? (~q_mag + 1'b1) : q_mag;
      rs    = r_neg ? (~r_mag + 1'b1) : r_mag;
      quo_f = qs & mask;
      rem_f = rs & mask;
   end
endmodule

// File: rtl/divx_top.sv
module divx_top #(
   parameter int WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                size_word,
   input  logic                is_signed,
   input  logic [2*WORD_W-1:0] dividend,
   input  logic [WORD_W-1:0]   divisor,
   output logic                busy,
   output logic                done,
   output logic [2*WORD_W-1:0] result,
   output logic                quo_zero,
   output logic                quo_neg,
   output logic                div_zero,
   output logic                overflow
);
   import divx_pkg::*;

   localparam int W  = WORD_W;
   localparam int H  = W / 2;
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_width
         $error("divx_top: WORD_W must be even and at least 4");
      end
   endgenerate

   divx_state_e    st_q;
   logic [CW-1:0]  cnt_q;
   logic [2*W-1:0] saved_q;
   logic           word_q, sgn_q, qneg_q, rneg_q, dz_q, hov_q;

   logic [W-1:0] p_init, q_init, d_mag, rem_mag, quo_mag, quo_f, rem_f;
   logic         dvd_neg, dvs_neg, dz_c, hov_c, fix_ovf;
   logic         load, step, err;

   divx_prep #(.W(W)) u_prep (
      .dividend(dividend), .divisor(divisor), .size_word(size_word),
      .is_signed(is_signed), .p_init(p_init), .q_init(q_init),
      .d_mag(d_mag), .dvd_neg(dvd_neg), .dvs_neg(dvs_neg),
      .div_zero(dz_c), .hi_ovf(hov_c));

   assign load = (st_q == ST_IDLE) && start;
   assign step = (st_q == ST_RUN);

   divx_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .p_init(p_init), .q_init(q_init), .d_init(d_mag),
      .rem_mag(rem_mag), .quo_mag(quo_mag));

   divx_fix #(.W(W)) u_fix (
      .q_mag(quo_mag), .r_mag(rem_mag), .size_word(word_q),
      .is_signed(sgn_q), .q_neg(qneg_q), .r_neg(rneg_q),
      .quo_f(quo_f), .rem_f(rem_f), .ovf(fix_ovf));

   assign err  = dz_q | hov_q | fix_ovf;
   assign busy = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         saved_q  <= '0;
         word_q   <= 1'b0;
         sgn_q    <= 1'b0;
         qneg_q   <= 1'b0;
         rneg_q   <= 1'b0;
         dz_q     <= 1'b0;
         hov_q    <= 1'b0;
         done     <= 1'b0;
         result   <= '0;
         quo_zero <= 1'b0;
         quo_neg  <= 1'b0;
         div_zero <= 1'b0;
         overflow <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               saved_q <= dividend;
               word_q  <= size_word;
               sgn_q   <= is_signed;
               qneg_q  <= dvd_neg ^ dvs_neg;
               rneg_q  <= dvd_neg;
               dz_q    <= dz_c;
               hov_q   <= hov_c;
               cnt_q   <= size_word ? CW'(W - 1) : CW'(H - 1);
               st_q    <= (dz_c || hov_c) ? ST_FIX : ST_RUN;
            end
            ST_RUN: begin
               if (cnt_q == '0) st_q <= ST_FIX;
               else cnt_q <= cnt_q - 1'b1;
            end
            default: begin
               st_q     <= ST_IDLE;
               done     <= 1'b1;
               div_zero <= dz_q;
               overflow <= !dz_q && err;
               if (err) begin
                  result   <= saved_q;
                  quo_zero <= 1'b0;
                  quo_neg  <= 1'b0;
               end else begin
                  result   <= word_q ? {rem_f, quo_f}
                                     : {saved_q[2*W-1:W], rem_f[H-1:0], quo_f[H-1:0]};
                  quo_zero <= (quo_f == '0);
                  quo_neg  <= word_q ? quo_f[W-1] : quo_f[H-1];
               end
            end
         endcase
      end
   end

   // R7: done lasts one cycle and never overlaps busy
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R4: divide by zero returns the dividend with clear quotient flags
   a_r4_div0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (result == saved_q && !quo_zero && !quo_neg && !overflow));
   // R5: overflow returns the dividend
   a_r5_ovf_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && overflow) |-> (result == saved_q && !quo_zero && !quo_neg));
   // R3: nonzero signed remainder carries the dividend sign
   a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sgn_q && !div_zero && !overflow &&
       (word_q ? result[2*W-1:W] != '0 : result[W-1:H] != '0))
      |-> ((word_q ? result[2*W-1] : result[W-1]) == rneg_q));
   // R8: captured operands do not change while busy
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(saved_q));
endmodule

// File: tb/sim_divx_top.sv
module sim_divx_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        size_word = 1'b0;
   logic        is_signed = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, quo_zero, quo_neg, div_zero, overflow;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   divx_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
      .is_signed(is_signed), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .result(result), .quo_zero(quo_zero),
      .quo_neg(quo_neg), .div_zero(div_zero), .overflow(overflow));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         chk(1'b0, "R7 watchdog", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // reference model: returns {res, zero, neg, dz, ovf, latency}
   task automatic model(input bit sz, input bit sg, input logic [31:0] dvd,
                        input logic [15:0] dvs, output logic [31:0] res,
                        output bit z, output bit n, output bit dz, output bit ov,
                        output int lat);
      longint a, b, q, r;
      int nb;
      nb = sz ? 16 : 8;
      if (sz) begin
         if (sg) begin a = longint'($signed(dvd)); b = longint'($signed(dvs)); end
         else begin a = longint'({32'd0, dvd}); b = longint'({48'd0, dvs}); end
      end else begin
         if (sg) begin a = longint'($signed(dvd[15:0])); b = longint'($signed(dvs[7:0])); end
         else begin a = longint'({48'd0, dvd[15:0]}); b = longint'({56'd0, dvs[7:0]}); end
      end
      res = dvd; z = 0; n = 0; dz = 0; ov = 0; lat = 2;
      if (b == 0) begin
         dz = 1;
      end else begin
         q = a / b;
         r = a % b;
         if (sg) ov = (q < -(64'sd1 <<< (nb - 1))) || (q > ((64'sd1 <<< (nb - 1)) - 1));
         else    ov = (q > ((64'sd1 <<< nb) - 1));
         if (!ov) begin
            if (sz) res = {r[15:0], q[15:0]};
            else    res = {dvd[31:16], r[7:0], q[7:0]};
            z = sz ? (q[15:0] == 0) : (q[7:0] == 0);
            n = sz ? q[15] : q[7];
            lat = nb + 2;
         end else begin
            // overflow visible in the high half is reported early
            longint ahi, bm;
            ahi = (a < 0) ? -a : a;
            bm  = (b < 0) ? -b : b;
            lat = ((ahi >> nb) >= bm) ? 2 : nb + 2;
         end
      end
   endtask

   task automatic run_op(input bit sz, input bit sg, input logic [31:0] dvd,
                         input logic [15:0] dvs, input bit disturb, input string tag);
      logic [31:0] eres;
      bit ez, en, edz, eov;
      int elat, k;
      model(sz, sg, dvd, dvs, eres, ez, en, edz, eov, elat);
      @(negedge clk);
      size_word = sz; is_signed = sg; dividend = dvd; divisor = dvs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 40) begin
         if (k == 1) chk(busy === 1'b1, {tag, " R7 busy"}, 32'(busy), 1);
         if (disturb && k == 3) begin
            start = 1'b1; dividend = ~dvd; divisor = dvs + 16'd3;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      chk(done === 1'b1 && k == elat, {tag, " R7 latency"}, 32'(k), 32'(elat));
      chk(result === eres, {tag, " result"}, result, eres);
      chk({quo_zero, quo_neg, div_zero, overflow} === {ez, en, edz, eov},
          {tag, " R6 flags"}, 32'({quo_zero, quo_neg, div_zero, overflow}),
          32'({ez, en, edz, eov}));
      @(negedge clk);
      chk(!done && !busy, {tag, " R7 pulse"}, 32'({done, busy}), 0);
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      chk(!busy && !done && result == 0 && !div_zero && !overflow,
          "reset state", result, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 byte unsigned with ignored upper bits
      run_op(0, 0, 32'hABCD_0064, 16'hFF07, 0, "R1 100/7");
      run_op(0, 0, 32'h1234_00FF, 16'h0001, 0, "R1 255/1");
      // R2 word unsigned
      run_op(1, 0, 32'h0001_2345, 16'h0100, 0, "R2 word");
      run_op(1, 0, 32'h0000_0005, 16'h0009, 0, "R2 zero quotient");
      // R3 signed sign combinations, byte
      run_op(0, 1, 32'h0000_FFF9, 16'h0002, 0, "R3 -7/2");
      run_op(0, 1, 32'h0000_0007, 16'h00FE, 0, "R3 7/-2");
      run_op(0, 1, 32'h0000_FFF9, 16'h00FE, 0, "R3 -7/-2");
      run_op(1, 1, 32'hFFFF_FF9C, 16'h0007, 0, "R3 word -100/7");
      // R5 signed bounds
      run_op(0, 1, 32'h0000_FF80, 16'h0001, 0, "R5 -128/1 fits");
      run_op(0, 1, 32'h0000_0080, 16'h0001, 0, "R5 128/1 ovf");
      run_op(0, 1, 32'h0000_FF80, 16'h00FF, 0, "R5 -128/-1 ovf");
      run_op(1, 0, 32'h0001_0000, 16'h0001, 0, "R5 word unsigned ovf");
      run_op(1, 1, 32'h8000_0000, 16'hFFFF, 0, "R5 word signed ovf");
      // R4 divide by zero, upper divisor bits ignored in byte size
      run_op(0, 0, 32'h5555_1234, 16'h0100, 0, "R4 byte div0");
      run_op(1, 1, 32'h8765_4321, 16'h0000, 0, "R4 word div0");
      // R8 start while busy
      run_op(1, 0, 32'h0000_9876, 16'h0033, 1, "R8 word disturb");
      run_op(0, 1, 32'h0000_F123, 16'h0045, 1, "R8 byte disturb");

      for (int i = 0; i < 300; i++) begin
         logic [31:0] d;
         logic [15:0] v;
         d = $urandom >> ($urandom % 24);
         v = 16'($urandom >> ($urandom % 20));
         if (($urandom % 4) == 0) d = ~d;
         run_op(1'($urandom), 1'($urandom), d, v, 0, "R1 R2 R3 R5 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule